// File: doc/BRIEF.md
# Byte-Command Acquisition Configuration Controller

This block is the control state machine of a two-channel capture front end. A host steers it with single command bytes. Each byte the machine accepts moves it at most one step. It then answers with a reply byte that carries the code of the state it has just entered. The machine has four operating modes: idle, trigger-armed, readout and scroll. It also has a fixed chain of parameter states, and each of these takes exactly one byte and stores it in a configuration field.

The chain begins with two channel-number states in a row, which both report code 0x0F. The channel is updated only when the two bytes agree. The chain then loads, in order, the sample-rate index, the two decimation steps, the two coupling bytes, the subset shift, the edge selection, two positions, the trigger level and two offset/gain pairs. After the last of these it returns to idle. Calibration bytes (positions, offsets, gains) are first held in staging registers. They reach the outputs only while the machine sits in idle or scroll, so an armed capture never sees them move.

Commands arrive over a valid/ready byte stream, and replies leave over a second one. The controller holds at most one reply. It drops `cmd_ready` while a reply is waiting, so a slow reply consumer stalls the command source without losing data. A trigger event is remembered while the machine is armed, and is cleared each time the armed state is entered.

Top module: `acq_cfg_ctrl`

## Requirements
- R1: After reset the state is the power-up code 0x00 with `cmd_ready` low, no reply and all configuration outputs zero. On the first clock edge after reset release the machine enters idle (0x01) without producing a reply, and it never returns to 0x00.
- R2: In idle (0x01), command 0x02 enters armed (0x21), 0x03 enters readout (0x03) and 0x04 enters scroll (0x14).
- R3: In armed, command 0x99 moves to readout (0x03) if a trigger is pending, and otherwise leaves the state at 0x21. A one-cycle high pulse on `trig_evt` while armed makes a trigger pending.
- R4: In armed, command 0xFE stays in 0x21 but makes a trigger pending, so the next 0x99 reaches 0x03. Command 0xFF aborts to 0x03 whether or not a trigger is pending.
- R5: `trig_evt` pulses outside the armed state have no effect, and entering 0x21 clears any pending trigger.
- R6: Command 0x04 in readout and command 0xFF in scroll both enter the first channel state (code 0x0F).
- R7: The two channel states each take one byte, and both report 0x0F. `cfg_channel` takes the second byte only if it equals the first. Otherwise it keeps its old value. In either case the next state is 0x05.
- R8: After the channel states, each accepted byte is stored and the state advances in this fixed order of reply codes: 0x05 rate → 0x08 step of subset 2 → 0x09 step of subset 1 → 0x06 coupling A → 0x07 coupling B → 0x0A shift → 0x0B edge → 0x0C position A → 0x0D position B → 0x0E trigger level → 0x10 offset A → 0x11 gain A → 0x12 offset B → 0x13 gain B → 0x01 idle. Each non-calibration output shows its byte from the clock edge that accepts it.
- R9: The calibration outputs (positions, offsets, gains) change only on a clock edge at which the state is idle or scroll. While the machine is in any other state they hold, and they take the staged bytes one cycle after the return to idle.
- R10: A command byte not defined for the current idle, armed, readout or scroll state leaves the state unchanged, and the reply repeats the current code.
- R11: Every accepted command (`cmd_valid` and `cmd_ready` both high) makes `rep_valid` high on the next cycle, with `rep_data` equal to the new state code. The reply stays stable until `rep_ready` is high, and `cmd_ready` is low while a reply is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_data | input | 8 | Command or parameter byte |
| rep_valid | output | 1 | Reply byte pending |
| rep_ready | input | 1 | Consumer takes the reply |
| rep_data | output | 8 | Code of the state entered |
| trig_evt | input | 1 | Trigger event pulse |
| cfg_channel | output | 8 | Agreed channel number |
| cfg_rate | output | 8 | Sample-rate index |
| cfg_step_b | output | 8 | Step + 1 for the second subset |
| cfg_step_a | output | 8 | Step + 1 for the first subset |
| cfg_cpl_a | output | 8 | Coupling/gain byte A with trigger source |
| cfg_cpl_b | output | 8 | Coupling/gain byte B with trigger type |
| cfg_shift | output | 8 | Subset shift + 1 |
| cfg_edge | output | 8 | Trigger edge selection |
| cfg_tlevel | output | 8 | Trigger level |
| cal_pos_a | output | 8 | Applied position, channel A |
| cal_pos_b | output | 8 | Applied position, channel B |
| cal_ofs_a | output | 8 | Applied offset, channel A |
| cal_gain_a | output | 8 | Applied gain, channel A |
| cal_ofs_b | output | 8 | Applied offset, channel B |
| cal_gain_b | output | 8 | Applied gain, channel B |

## Verification
The assertions check the following on every cycle: the single power-up exit, the reply timing and hold under back-pressure, stray commands leaving idle untouched, the armed poll without a pending trigger, the abort, calibration freezing outside idle and scroll, and channel updates coming only out of a channel state. Other behaviours can only be shown by the bench's scenarios. These are the exact byte-to-field mapping along the chain, the agreement rule on the channel pair, the stickiness and clearing of the trigger, and the sweeps over all 256 byte values in idle, armed and scroll.

// File: rtl/acq_cfg_pkg.sv
package acq_cfg_pkg;

  localparam int BYTE_W = 8;

  // Internal state order: chain states must stay consecutive (ST_RATE..ST_GAIN2)
  typedef enum logic [4:0] {
    ST_PWRUP, ST_IDLE, ST_ARMED, ST_READ, ST_SCROLL,
    ST_CH_A, ST_CH_B,
    ST_RATE, ST_STEP2, ST_STEP1, ST_CPL0, ST_CPL1, ST_SHIFT, ST_EDGE,
    ST_POS1, ST_POS2, ST_TLVL, ST_OFS1, ST_GAIN1, ST_OFS2, ST_GAIN2
  } st_e;

  // Field slots: non-calibration first, calibration from CAL_BASE upward
  typedef enum logic [3:0] {
    F_RATE, F_STEP2, F_STEP1, F_CPL0, F_CPL1, F_SHIFT, F_EDGE, F_TLVL,
    F_POS1, F_POS2, F_OFS1, F_GAIN1, F_OFS2, F_GAIN2
  } fld_e;

  localparam int NUM_FIELDS = 14;
  localparam int CAL_BASE   = 8;

  localparam logic [BYTE_W-1:0] CMD_ARM    = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_NEXT   = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_POLL   = 8'h99;
  localparam logic [BYTE_W-1:0] CMD_FORCE  = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_ABORT  = 8'hFF;

  function automatic logic [BYTE_W-1:0] st_code(st_e s);
    case (s)
      ST_PWRUP:  return 8'h00;
      ST_IDLE:   return 8'h01;
      ST_ARMED:  return 8'h21;
      ST_READ:   return 8'h03;
      ST_SCROLL: return 8'h14;
      ST_CH_A:   return 8'h0F;
      ST_CH_B:   return 8'h0F;
      ST_RATE:   return 8'h05;
      ST_STEP2:  return 8'h08;
      ST_STEP1:  return 8'h09;
      ST_CPL0:   return 8'h06;
      ST_CPL1:   return 8'h07;
      ST_SHIFT:  return 8'h0A;
      ST_EDGE:   return 8'h0B;
      ST_POS1:   return 8'h0C;
      ST_POS2:   return 8'h0D;
      ST_TLVL:   return 8'h0E;
      ST_OFS1:   return 8'h10;
      ST_GAIN1:  return 8'h11;
      ST_OFS2:   return 8'h12;
      ST_GAIN2:  return 8'h13;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic is_load(st_e s);
    return (s >= ST_RATE) && (s <= ST_GAIN2);
  endfunction

  function automatic fld_e st_field(st_e s);
    case (s)
      ST_RATE:  return F_RATE;
      ST_STEP2: return F_STEP2;
      ST_STEP1: return F_STEP1;
      ST_CPL0:  return F_CPL0;
      ST_CPL1:  return F_CPL1;
      ST_SHIFT: return F_SHIFT;
      ST_EDGE:  return F_EDGE;
      ST_POS1:  return F_POS1;
      ST_POS2:  return F_POS2;
      ST_TLVL:  return F_TLVL;
      ST_OFS1:  return F_OFS1;
      ST_GAIN1: return F_GAIN1;
      ST_OFS2:  return F_OFS2;
      default:  return F_GAIN2;
    endcase
  endfunction

endpackage

// File: rtl/acq_trig_latch.sv
module acq_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_armed,
  input  logic enter_armed,
  input  logic force_trig,
  input  logic trig_evt,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (enter_armed)
      pending <= 1'b0;
    else if (in_armed && (trig_evt || force_trig))
      pending <= 1'b1;
  end
endmodule

// File: rtl/acq_cfg_fsm.sv
module acq_cfg_fsm
  import acq_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] cmd,
  input  logic              trig_pending,
  output st_e               st_q,
  output st_e               st_d
);
  always_comb begin
    st_d = st_q;
    if (st_q == ST_PWRUP) begin
      st_d = ST_IDLE;
    end else if (fire) begin
      case (st_q)
        ST_IDLE: begin
          if (cmd == CMD_ARM)       st_d = ST_ARMED;
          else if (cmd == CMD_READ) st_d = ST_READ;
          else if (cmd == CMD_NEXT) st_d = ST_SCROLL;
        end
        ST_ARMED: begin
          if (cmd == CMD_ABORT)                     st_d = ST_READ;
          else if (cmd == CMD_POLL && trig_pending) st_d = ST_READ;
        end
        ST_READ:   if (cmd == CMD_NEXT)  st_d = ST_CH_A;
        ST_SCROLL: if (cmd == CMD_ABORT) st_d = ST_CH_A;
        ST_GAIN2:  st_d = ST_IDLE;
        default:   st_d = st_e'(st_q + 5'd1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_PWRUP;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/acq_cfg_regfile.sv
module acq_cfg_regfile
  import acq_cfg_pkg::*;
#(
  parameter int W       = BYTE_W,
  parameter int NFLD    = NUM_FIELDS,
  parameter int CALBASE = CAL_BASE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  st_e                    st_q,
  input  logic                   wr_en,
  input  logic [W-1:0]           wr_data,
  input  logic                   apply_en,
  output logic [W-1:0]           channel,
  output logic [NFLD-1:0][W-1:0] fld_q
);
  logic [W-1:0] ch_first;
  logic         load_now;
  logic [3:0]   load_idx;

  assign load_now = wr_en && is_load(st_q);
  assign load_idx = st_field(st_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_first <= '0;
      channel  <= '0;
    end else if (wr_en) begin
      if (st_q == ST_CH_A)
        ch_first <= wr_data;
      else if (st_q == ST_CH_B && wr_data == ch_first)
        channel <= wr_data;
    end
  end

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    logic hit;
    assign hit = load_now && (int'(load_idx) == i);
    if (i < CALBASE) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)   fld_q[i] <= '0;
        else if (hit) fld_q[i] <= wr_data;
      end
    end else begin : g_staged
      logic [W-1:0] stage_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q  <= '0;
          fld_q[i] <= '0;
        end else begin
          if (hit)      stage_q  <= wr_data;
          if (apply_en) fld_q[i] <= stage_q;
        end
      end
    end
  end
endmodule

// File: rtl/acq_cfg_ctrl.sv
module acq_cfg_ctrl
  import acq_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [BYTE_W-1:0] rep_data,
  input  logic              trig_evt,
  output logic [BYTE_W-1:0] cfg_channel,
  output logic [BYTE_W-1:0] cfg_rate,
  output logic [BYTE_W-1:0] cfg_step_b,
  output logic [BYTE_W-1:0] cfg_step_a,
  output logic [BYTE_W-1:0] cfg_cpl_a,
  output logic [BYTE_W-1:0] cfg_cpl_b,
  output logic [BYTE_W-1:0] cfg_shift,
  output logic [BYTE_W-1:0] cfg_edge,
  output logic [BYTE_W-1:0] cfg_tlevel,
  output logic [BYTE_W-1:0] cal_pos_a,
  output logic [BYTE_W-1:0] cal_pos_b,
  output logic [BYTE_W-1:0] cal_ofs_a,
  output logic [BYTE_W-1:0] cal_gain_a,
  output logic [BYTE_W-1:0] cal_ofs_b,
  output logic [BYTE_W-1:0] cal_gain_b
);
  st_e  st_q, st_d;
  logic fire;
  logic trig_pend;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld_q;
  logic [BYTE_W-1:0] cur_code;
  logic [6*BYTE_W-1:0] cal_all;

  assign cmd_ready = (st_q != ST_PWRUP) && !rep_valid;
  assign fire      = cmd_valid && cmd_ready;
  assign cur_code  = st_code(st_q);

  acq_cfg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd_data),
    .trig_pending(trig_pend), .st_q(st_q), .st_d(st_d)
  );

  acq_trig_latch u_trig (
    .clk(clk), .rst_n(rst_n),
    .in_armed(st_q == ST_ARMED),
    .enter_armed((st_d == ST_ARMED) && (st_q != ST_ARMED)),
    .force_trig(fire && (st_q == ST_ARMED) && (cmd_data == CMD_FORCE)),
    .trig_evt(trig_evt),
    .pending(trig_pend)
  );

  acq_cfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .st_q(st_q),
    .wr_en(fire), .wr_data(cmd_data),
    .apply_en((st_q == ST_IDLE) || (st_q == ST_SCROLL)),
    .channel(cfg_channel), .fld_q(fld_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_data  <= '0;
    end else if (fire) begin
      rep_valid <= 1'b1;
      rep_data  <= st_code(st_d);
    end else if (rep_ready) begin
      rep_valid <= 1'b0;
    end
  end

  assign cfg_rate   = fld_q[F_RATE];
  assign cfg_step_b = fld_q[F_STEP2];
  assign cfg_step_a = fld_q[F_STEP1];
  assign cfg_cpl_a  = fld_q[F_CPL0];
  assign cfg_cpl_b  = fld_q[F_CPL1];
  assign cfg_shift  = fld_q[F_SHIFT];
  assign cfg_edge   = fld_q[F_EDGE];
  assign cfg_tlevel = fld_q[F_TLVL];
  assign cal_pos_a  = fld_q[F_POS1];
  assign cal_pos_b  = fld_q[F_POS2];
  assign cal_ofs_a  = fld_q[F_OFS1];
  assign cal_gain_a = fld_q[F_GAIN1];
  assign cal_ofs_b  = fld_q[F_OFS2];
  assign cal_gain_b = fld_q[F_GAIN2];
  assign cal_all    = {cal_pos_a, cal_pos_b, cal_ofs_a, cal_gain_a, cal_ofs_b, cal_gain_b};
endmodule

// File: rtl/acq_cfg_chk.sv
module acq_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_data,
  input logic        rep_valid,
  input logic        rep_ready,
  input logic [7:0]  rep_data,
  input logic [7:0]  state_code,
  input logic        trig_pending,
  input logic [7:0]  channel,
  input logic [47:0] cal_bus
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_PWRUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 8'h00 |=> state_code == 8'h01); // R1
  AST_NO_PWRUP_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 8'h00 |=> state_code != 8'h00); // R1
  AST_REPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rep_valid && rep_data == state_code); // R11
  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_data)); // R11
  AST_IDLE_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 8'h01 && fire && cmd_data != 8'h02 && cmd_data != 8'h03 && cmd_data != 8'h04
    |=> state_code == 8'h01); // R10
  AST_ARMED_NOTRIG: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 8'h21 && fire && cmd_data == 8'h99 && !trig_pending |=> state_code == 8'h21); // R3
  AST_ARMED_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 8'h21 && fire && cmd_data == 8'hFF |=> state_code == 8'h03); // R4
  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 8'h01 && state_code != 8'h14 |=> $stable(cal_bus)); // R9
  AST_CHAN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(channel) |-> $past(state_code) == 8'h0F); // R7
endmodule

bind acq_cfg_ctrl acq_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .rep_data(rep_data), .state_code(cur_code), .trig_pending(trig_pend),
  .channel(cfg_channel), .cal_bus(cal_all)
);

// File: tb/tb_acq_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_acq_cfg_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic rep_ready = 1'b0;
  logic trig_evt = 1'b0;
  logic cmd_ready, rep_valid;
  logic [7:0] rep_data;
  logic [7:0] cfg_channel, cfg_rate, cfg_step_b, cfg_step_a, cfg_cpl_a, cfg_cpl_b;
  logic [7:0] cfg_shift, cfg_edge, cfg_tlevel;
  logic [7:0] cal_pos_a, cal_pos_b, cal_ofs_a, cal_gain_a, cal_ofs_b, cal_gain_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_ch = 8'h00;
  logic [7:0] exp_val [14];
  logic [7:0] applied [14];

  always #4 clk = ~clk;

  acq_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rep_valid(rep_valid), .rep_ready(rep_ready),
    .rep_data(rep_data), .trig_evt(trig_evt), .cfg_channel(cfg_channel),
    .cfg_rate(cfg_rate), .cfg_step_b(cfg_step_b), .cfg_step_a(cfg_step_a),
    .cfg_cpl_a(cfg_cpl_a), .cfg_cpl_b(cfg_cpl_b), .cfg_shift(cfg_shift),
    .cfg_edge(cfg_edge), .cfg_tlevel(cfg_tlevel), .cal_pos_a(cal_pos_a),
    .cal_pos_b(cal_pos_b), .cal_ofs_a(cal_ofs_a), .cal_gain_a(cal_gain_a),
    .cal_ofs_b(cal_ofs_b), .cal_gain_b(cal_gain_b)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // chain index k: 0 rate,1 step2,2 step1,3 cpl0,4 cpl1,5 shift,6 edge,
  // 7 pos1,8 pos2,9 tlevel,10 ofs1,11 gain1,12 ofs2,13 gain2
  function automatic logic [7:0] port_of(input int k);
    case (k)
      0: return cfg_rate;   1: return cfg_step_b; 2: return cfg_step_a;
      3: return cfg_cpl_a;  4: return cfg_cpl_b;  5: return cfg_shift;
      6: return cfg_edge;   7: return cal_pos_a;  8: return cal_pos_b;
      9: return cfg_tlevel; 10: return cal_ofs_a; 11: return cal_gain_a;
      12: return cal_ofs_b; default: return cal_gain_b;
    endcase
  endfunction

  function automatic logic [7:0] code_after(input int k);
    case (k)
      0: return 8'h08;  1: return 8'h09;  2: return 8'h06;  3: return 8'h07;
      4: return 8'h0A;  5: return 8'h0B;  6: return 8'h0C;  7: return 8'h0D;
      8: return 8'h0E;  9: return 8'h10; 10: return 8'h11; 11: return 8'h12;
      12: return 8'h13; default: return 8'h01;
    endcase
  endfunction

  function automatic bit is_cal(input int k);
    return (k == 7) || (k == 8) || (k >= 10);
  endfunction

  task automatic send(input logic [7:0] c, output logic [7:0] r);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 reply valid", {7'd0, rep_valid}, 8'h01);
    r = rep_data;
    rep_ready = 1'b1;
    @(negedge clk);
    rep_ready = 1'b0;
  endtask

  task automatic send_exp(input logic [7:0] c, input logic [7:0] exp, input string req);
    logic [7:0] r;
    send(c, r);
    check(req, r, exp);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig_evt = 1'b1;
    @(negedge clk);
    trig_evt = 1'b0;
  endtask

  // enter from the first channel state and walk the whole chain back to idle
  task automatic run_chain(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] base);
    send_exp(c1, 8'h0F, "R7 first channel byte");
    send_exp(c2, 8'h05, "R7 second channel byte");
    if (c1 == c2) exp_ch = c2;
    check("R7 channel agreement", cfg_channel, exp_ch);
    for (int k = 0; k < 14; k++) begin
      logic [7:0] v;
      v = base + 8'(k * 19);
      exp_val[k] = v;
      send_exp(v, code_after(k), "R8 chain order");
      if (!is_cal(k)) check("R8 field load", port_of(k), v);
      else if (k < 13) check("R9 calibration held in chain", port_of(k), applied[k]);
    end
    repeat (2) @(negedge clk);
    for (int k = 0; k < 14; k++) begin
      if (is_cal(k)) begin
        applied[k] = exp_val[k];
        check("R9 calibration applied in idle", port_of(k), applied[k]);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 14; k++) applied[k] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset cmd_ready", {7'd0, cmd_ready}, 8'h00);
    check("R1 reset rep_valid", {7'd0, rep_valid}, 8'h00);
    for (int k = 0; k < 14; k++) check("R1 reset outputs", port_of(k), 8'h00);
    check("R1 reset channel", cfg_channel, 8'h00);
    rst_n = 1'b1;
    check("R1 power-up blocks commands", {7'd0, cmd_ready}, 8'h00);
    @(negedge clk);
    check("R1 idle ready", {7'd0, cmd_ready}, 8'h01);
    check("R1 no reply on auto step", {7'd0, rep_valid}, 8'h00);

    // sweep all bytes in idle except the three mode commands
    for (int c = 0; c < 256; c++)
      if (c != 2 && c != 3 && c != 4) send_exp(8'(c), 8'h01, "R10 idle stray");

    send_exp(8'h04, 8'h14, "R2 idle to scroll");
    for (int c = 0; c < 255; c++) send_exp(8'(c), 8'h14, "R10 scroll stray");
    send_exp(8'hFF, 8'h0F, "R6 scroll to channel");
    run_chain(8'h02, 8'h02, 8'h31);

    send_exp(8'h03, 8'h03, "R2 idle to readout");
    for (int c = 0; c < 256; c++)
      if (c != 4) send_exp(8'(c), 8'h03, "R10 readout stray");
    send_exp(8'h04, 8'h0F, "R6 readout to channel");
    run_chain(8'h01, 8'h02, 8'h57);
    check("R7 mismatch keeps channel", cfg_channel, 8'h02);

    // armed: poll without trigger, sweep strays, then real trigger
    send_exp(8'h02, 8'h21, "R2 idle to armed");
    send_exp(8'h99, 8'h21, "R3 poll no trigger");
    for (int c = 0; c < 256; c++)
      if (c != 8'h99 && c != 8'hFE && c != 8'hFF) send_exp(8'(c), 8'h21, "R10 armed stray");
    pulse_trig();
    send_exp(8'h99, 8'h03, "R3 poll after trigger");
    send_exp(8'h04, 8'h0F, "R6 readout to channel");
    run_chain(8'h01, 8'h01, 8'h8B);

    // trigger outside armed ignored; forced trigger
    pulse_trig();
    send_exp(8'h02, 8'h21, "R5 arm after idle trigger");
    send_exp(8'h99, 8'h21, "R5 idle trigger ignored");
    send_exp(8'hFE, 8'h21, "R4 force stays armed");
    send_exp(8'h99, 8'h03, "R4 poll after force");
    send_exp(8'h04, 8'h0F, "R6 readout to channel");
    run_chain(8'h02, 8'h03, 8'hC4);

    // pending trigger cleared by re-entry
    send_exp(8'h02, 8'h21, "R2 idle to armed");
    pulse_trig();
    send_exp(8'hFF, 8'h03, "R4 abort");
    send_exp(8'h04, 8'h0F, "R6 readout to channel");
    run_chain(8'h02, 8'h02, 8'h05);
    send_exp(8'h02, 8'h21, "R2 idle to armed");
    send_exp(8'h99, 8'h21, "R5 trigger cleared on entry");
    send_exp(8'hFF, 8'h03, "R4 abort without trigger");

    // reply back-pressure
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 8'h04;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h77;
    for (int i = 0; i < 3; i++) begin
      check("R11 reply held valid", {7'd0, rep_valid}, 8'h01);
      check("R11 reply held data", rep_data, 8'h0F);
      check("R11 ready low while pending", {7'd0, cmd_ready}, 8'h00);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    rep_ready = 1'b1;
    @(negedge clk);
    rep_ready = 1'b0;
    check("R11 reply released", {7'd0, rep_valid}, 8'h00);
    send_exp(8'h01, 8'h0F, "R11 held bytes not taken");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule